// File: doc/BRIEF.md
# Background Refresh Address Generator with Cycle Stealing

This block keeps a slowly leaking memory alive without stopping the processor. Each cycle it looks at the destination-register field of the instruction in flight. When the top bit of that field shows the destination is not one of the memory-linked registers, no memory write can happen in that cycle. The block then claims the memory address bus through an external multiplexer and asks the memory for a read-and-rewrite of one word.

Refresh addresses come from a linear feedback shift register with a single two-input XOR in its feedback, not from a binary counter. The register moves one step only in cycles where a refresh is actually taken. Two sizings are supported. In the wide sizing the register is wider than the address, and its low bits form the address, so address 0 gets refreshed too. In the exact sizing the register is as wide as the address, so it visits every nonzero address and never address 0. That suits a system in which word 0 is the program counter and needs no refresh.

Top module: `refresh_steal_gen`

## Requirements
- R1: While reset is asserted and directly after it is released, the shift register holds all ones, so `refresh_addr` reads all ones (0x1FF for a 9-bit address) and `refresh_req` and `addr_sel` are 0 during reset.
- R2: Outside reset, a refresh slot is granted in a cycle exactly when the top bit of `dst_field` differs from the memory-linked marker (default marker 1, so a top bit of 0 means a free slot). `refresh_req` and `addr_sel` are both 1 in a granted cycle and both 0 otherwise, in that same cycle.
- R3: The bits of `dst_field` below the top bit have no effect on the grant or on the address sequence.
- R4: On a clock edge without a grant the shift register and `refresh_addr` hold their value.
- R5: On a clock edge with a grant the register shifts one place toward its top bit, and its new bit 0 is the XOR of the old top bit and old bit TAP-1. TAP follows from the width: 2→1, 3→2, 4→3, 5→3, 6→5, 7→6, 9→5, 10→7, 11→9.
- R6: `refresh_addr` is the low ADDR_W bits of the shift register state.
- R7: With the default 11-bit register and 9-bit address, the address sequence over grants repeats every 2047 grants, and address 0 appears exactly 3 times in each period.
- R8: With a 9-bit register and 9-bit address, any 511 consecutive grants present every nonzero address exactly once and never address 0.
- R9: The shift register never holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads all ones |
| dst_field | input | DST_W | Destination-register field of the current instruction |
| addr_sel | output | 1 | Address multiplexer select: 1 puts `refresh_addr` on the memory bus |
| refresh_addr | output | ADDR_W | Address of the word to refresh |
| refresh_req | output | 1 | Read-and-rewrite request for this cycle |

## Verification
The checks assume that `dst_field` is stable and known around each rising clock edge, since the grant is a combinational decode that feeds the register's advance on that same edge. They also assume the parameters name a width from the supported table. The bench changes `dst_field` just after each rising edge and holds it until the next one. It runs both a wide and an exact instance. It covers long idle stretches with every low-bit pattern, mixed patterns, and long unbroken grant runs, so that full address periods are seen.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

   // Second feedback tap (1-based) for a one-XOR maximal sequence; 0 = unsupported width.
   function automatic int unsigned lfsr_tap(input int unsigned width);
      case (width)
         2:       return 1;
         3:       return 2;
         4:       return 3;
         5:       return 3;
         6:       return 5;
         7:       return 6;
         9:       return 5;
         10:      return 7;
         11:      return 9;
         default: return 0;
      endcase
   endfunction

   typedef enum logic {
      SPAN_EXACT = 1'b0,   // register as wide as the address; word 0 never visited
      SPAN_WIDE  = 1'b1    // register wider than the address; low bits used
   } span_e;

endpackage

// File: rtl/refresh_slot_detect.sv
module refresh_slot_detect #(
   parameter logic MEM_MARK = 1'b1
) (
   input  logic rst_n,
   input  logic dst_top,
   output logic slot_free
);

   always_comb begin
      slot_free = rst_n && (dst_top != MEM_MARK);
   end

endmodule

// File: rtl/refresh_lfsr.sv
module refresh_lfsr #(
   parameter int unsigned WIDTH = 11,
   parameter int unsigned TAP   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [WIDTH-1:0] state
);

   localparam logic [WIDTH-1:0] SEED = {WIDTH{1'b1}};

   logic             feedback;
   logic [WIDTH-1:0] state_nxt;

   always_comb begin
      feedback  = state[WIDTH-1] ^ state[TAP-1];
      state_nxt = {state[WIDTH-2:0], feedback};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEED;
      end else if (advance) begin
         state <= state_nxt;
      end
   end

   // R9
   nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(state));

   // R5
   shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));

endmodule

// File: rtl/refresh_addr_tap.sv
module refresh_addr_tap #(
   parameter int unsigned LFSR_W = 11,
   parameter int unsigned ADDR_W = 9
) (
   input  logic [LFSR_W-1:0] state,
   output logic [ADDR_W-1:0] addr
);

   if (LFSR_W == ADDR_W) begin : g_exact
      always_comb addr = state;
   end else begin : g_wide
      logic unused_upper;
      always_comb begin
         addr         = state[ADDR_W-1:0];
         unused_upper = ^state[LFSR_W-1:ADDR_W];
      end
   end

endmodule

// File: rtl/refresh_steal_gen.sv
module refresh_steal_gen #(
   parameter int unsigned LFSR_W   = 11,
   parameter int unsigned ADDR_W   = 9,
   parameter int unsigned DST_W    = 3,
   parameter logic        MEM_MARK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DST_W-1:0]  dst_field,
   output logic              addr_sel,
   output logic [ADDR_W-1:0] refresh_addr,
   output logic              refresh_req
);
   import refresh_pkg::*;

   localparam int unsigned TAP  = lfsr_tap(LFSR_W);
   localparam span_e       SPAN = (LFSR_W == ADDR_W) ? SPAN_EXACT : SPAN_WIDE;

   if (TAP == 0) begin : g_bad_width
      $error("refresh_steal_gen: LFSR_W has no single-XOR tap entry");
   end
   if (ADDR_W > LFSR_W || ADDR_W < 1) begin : g_bad_addr
      $error("refresh_steal_gen: ADDR_W must be 1..LFSR_W");
   end
   if (DST_W < 2) begin : g_bad_dst
      $error("refresh_steal_gen: DST_W must be at least 2");
   end

   logic              slot_free;
   logic [LFSR_W-1:0] lfsr_state;
   logic              unused_dst_low;

   always_comb unused_dst_low = ^dst_field[DST_W-2:0];

   refresh_slot_detect #(
      .MEM_MARK (MEM_MARK)
   ) slot_i (
      .rst_n     (rst_n),
      .dst_top   (dst_field[DST_W-1]),
      .slot_free (slot_free)
   );

   refresh_lfsr #(
      .WIDTH (LFSR_W),
      .TAP   (TAP)
   ) lfsr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (slot_free),
      .state   (lfsr_state)
   );

   refresh_addr_tap #(
      .LFSR_W (LFSR_W),
      .ADDR_W (ADDR_W)
   ) tap_i (
      .state (lfsr_state),
      .addr  (refresh_addr)
   );

   always_comb begin
      addr_sel    = slot_free;
      refresh_req = slot_free;
   end

   // R2
   busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_field[DST_W-1] == MEM_MARK) |-> !refresh_req);

   // R2
   free_gets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_field[DST_W-1] != MEM_MARK) |-> (refresh_req && addr_sel));

   // R4
   addr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh_req |=> $stable(refresh_addr));

   if (SPAN == SPAN_EXACT) begin : g_exact_chk
      // R8
      no_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
         refresh_addr != '0);
   end

endmodule

// File: tb/refresh_steal_gen_tb_top.sv
module refresh_steal_gen_tb_top;

   typedef struct {
      logic       grant;
      logic [8:0] addr_w;
      logic [8:0] addr_n;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] dst = 3'b000;

   logic       sel_w, req_w, sel_n, req_n;
   logic [8:0] addr_w, addr_n;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   exp_t q[$];
   logic [8:0] log_w[$];
   logic [8:0] log_n[$];

   logic [10:0] mdl_w;
   logic [8:0]  mdl_n;

   always #2.5 clk = ~clk;

   refresh_steal_gen #(.LFSR_W(11), .ADDR_W(9), .DST_W(3), .MEM_MARK(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .dst_field(dst),
      .addr_sel(sel_w), .refresh_addr(addr_w), .refresh_req(req_w));

   refresh_steal_gen #(.LFSR_W(9), .ADDR_W(9), .DST_W(3), .MEM_MARK(1'b1)) dut_n9_i (
      .clk(clk), .rst_n(rst_n), .dst_field(dst),
      .addr_sel(sel_n), .refresh_addr(addr_n), .refresh_req(req_n));

   function automatic logic [10:0] step11(input logic [10:0] s);
      return {s[9:0], s[10] ^ s[8]};     // R5 tap 9
   endfunction
   function automatic logic [8:0] step9(input logic [8:0] s);
      return {s[7:0], s[8] ^ s[4]};      // R5 tap 5
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // driver: applies one field value for one cycle and queues the expected outputs
   task automatic drive(input logic [2:0] d);
      exp_t it;
      @(posedge clk);
      #1;
      dst = d;
      it.grant  = (d[2] == 1'b0);
      it.addr_w = mdl_w[8:0];
      it.addr_n = mdl_n;
      q.push_back(it);
      if (it.grant) begin
         mdl_w = step11(mdl_w);
         mdl_n = step9(mdl_n);
      end
   endtask

   // monitor: compares at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t it;
         it = q.pop_front();
         check(it.grant ? "R2 grant req" : "R3 idle req", {31'd0, req_w}, {31'd0, it.grant});
         check("R2 sel", {30'd0, sel_w, sel_n}, {30'd0, it.grant, it.grant});
         check("R5 R6 wide addr", {23'd0, addr_w}, {23'd0, it.addr_w});
         check("R4 R5 exact addr", {23'd0, addr_n}, {23'd0, it.addr_n});
         if (it.grant) begin
            log_w.push_back(addr_w);
            log_n.push_back(addr_n);
         end
      end
   end

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      mdl_w = '1;
      mdl_n = '1;
      // R1: free-slot field during reset must not request or move the register
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R1 reset req", {30'd0, req_w, req_n}, 32'd0);
      check("R1 reset sel", {30'd0, sel_w, sel_n}, 32'd0);
      check("R1 reset addr", {14'd0, addr_w, addr_n}, {14'd0, 9'h1FF, 9'h1FF});
      dst = 3'b100;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post reset addr", {14'd0, addr_w, addr_n}, {14'd0, 9'h1FF, 9'h1FF});

      // R3 R4: busy fields with every low pattern
      for (int i = 0; i < 16; i++) drive({1'b1, i[1:0]});
      // R3: free fields with every low pattern
      for (int i = 0; i < 8; i++) drive({1'b0, i[1:0]});
      // mixed pattern
      for (int i = 0; i < 40; i++) drive(((i % 3) == 0) ? 3'b110 : {1'b0, i[1], i[0]});
      // long unbroken grant runs, with occasional busy cycles
      for (int i = 0; i < 2200; i++) drive(((i % 97) == 50) ? 3'b101 : 3'b011);
      drive(3'b100);
      @(negedge clk);
      #1;

      // R8: first 511 grants of the exact instance
      begin
         bit seen[512];
         int distinct = 0;
         for (int i = 0; i < 512; i++) seen[i] = 1'b0;
         for (int i = 0; i < 511; i++) begin
            if (!seen[log_n[i]]) distinct++;
            seen[log_n[i]] = 1'b1;
         end
         check("R8 distinct nonzero addrs", distinct, 511);
         check("R8 R9 word0 never", {31'd0, seen[0]}, 32'd0);
         check("R8 period 511", {23'd0, log_n[511]}, {23'd0, log_n[0]});
      end

      // R7: wide instance period and zero count
      begin
         int zeros = 0;
         int mism = 0;
         for (int i = 0; i < 2047; i++) if (log_w[i] == 9'd0) zeros++;
         check("R7 zero addr count", zeros, 3);
         for (int i = 0; i + 2047 < log_w.size(); i++)
            if (log_w[i] != log_w[i + 2047]) mism++;
         check("R7 period 2047 repeat", mism, 0);
         check("R7 period not 511", {31'd0, log_w[511] == log_w[0] && log_w[512] == log_w[1]}, 32'd0);
      end

      done = 1'b1;
      finish_run();
   end

endmodule